// File: doc/BRIEF.md
# Interrupt Status, Mask and Acknowledge Unit

This block is the interrupt register set of a packet network controller. Seven event sources are gathered into an 8-bit status byte. Four of the bits are sticky: an event sets them and they stay set until software clears them. The other three bits follow live conditions in the rest of the controller. A mask byte chooses which status bits may drive the single active-high interrupt line.

Software reaches both bytes through one 16-bit register word. The low byte and the high byte can be accessed together or one at a time with byte enables. Reading the low byte returns the status. Writing the same low byte is an acknowledge: each 1 written clears the matching sticky bit. The high byte is the mask, and it can be read and written.

The block also contains an early-receive detector. It counts the bytes stored for the packet now arriving and compares that count with a programmable threshold. It raises its status bit once per packet.

Top module: `irq_reg_unit`

## Requirements
- R1: After reset, the status byte reads 0x04 (only the transmit-empty bit is set), the mask byte reads 0x00 and `irq` is low.
- R2: The status bit positions are: receive pending at bit 0, transmit done at bit 1, transmit empty at bit 2, allocation done at bit 3, receive overrun at bit 4, exception at bit 5, early receive at bit 6. Bit 7 always reads 0. Bit 0 follows `ev_rx_pending` and bit 3 follows `ev_alloc_done` directly, in the same cycle.
- R3: Bits 1, 2 and 4 are set by a one-cycle pulse on `ev_tx_done`, `ev_tx_empty` and `ev_rx_overrun`. Each stays set until a low-byte write with `hp_be[0]`=1 puts a 1 in its position. It reads 0 from the first cycle after that write.
- R4: In an acknowledge write, a 1 in bit position 0, 3, 5 or 7 has no effect, and a 0 in any position has no effect.
- R5: Bit 5 is the OR of all `exc_src` lines. An acknowledge does not clear it. It clears only when every source is low.
- R6: When a set event and an acknowledge of the same sticky bit arrive in the same cycle, the bit ends up set.
- R7: The mask is an 8-bit read/write byte in `hp_wdata[15:8]`. A read returns {mask, status} on `hp_rdata`.
- R8: The register word is at word address 6, which is byte offsets 0xC and 0xD. `hp_be[0]` selects the status/acknowledge byte and `hp_be[1]` selects the mask byte. A write with a byte enable low leaves that byte alone. Accesses to any other address have no effect, and reads there return 0.
- R9: `irq` is high exactly when (status AND mask) is nonzero.
- R10: A pulse on `rx_start` clears the byte count to 0 and arms the detector. Each `rx_byte_stb` adds 1 to the count. While armed and `rx_active`=1, the first cycle with count > `erx_threshold` sets bit 6, one cycle after the count reaches that value. The detector then disarms until the next `rx_start`. Bit 6 is sticky and is acknowledged like R3.
- R11: Reading the register word has no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hp_req | input | 1 | Host access strobe |
| hp_we | input | 1 | 1 = write, 0 = read |
| hp_addr | input | ADDR_W | Host word address |
| hp_be | input | 2 | Byte enables: bit 0 = status/acknowledge byte, bit 1 = mask byte |
| hp_wdata | input | 16 | Write data |
| hp_rdata | output | 16 | Read data {mask, status}; 0 when not addressed |
| ev_rx_pending | input | 1 | Live receive-queue-not-empty level |
| ev_alloc_done | input | 1 | Live allocation-complete level |
| ev_tx_done | input | 1 | Transmit-done event pulse |
| ev_tx_empty | input | 1 | Transmit-queue-empty event pulse |
| ev_rx_overrun | input | 1 | Receive-overrun event pulse |
| exc_src | input | NEXC | Protocol exception source levels |
| rx_start | input | 1 | Start-of-packet pulse for the early-receive detector |
| rx_active | input | 1 | High while a packet is being received |
| rx_byte_stb | input | 1 | One received byte stored |
| erx_threshold | input | CNT_W | Early-receive byte threshold |
| irq | output | 1 | Active-high interrupt |

## Verification
A sticky bit that is lost, or that fails to clear, shows up on the next status read. It can also show through `irq`, which follows the registered state without delay, so the error is visible one cycle after the event or acknowledge that caused it. A mask register holding a wrong value shows on every word read and in the sweep of `irq` against each mask value. A wrong count or arm flag in the early-receive detector moves the set of bit 6 by at least one byte strobe. Lost disarming shows as the bit setting again after an acknowledge within the same packet.

// File: rtl/irqu_pkg.sv
package irqu_pkg;
  localparam int SW = 8;
  localparam int B_RX      = 0;
  localparam int B_TXDONE  = 1;
  localparam int B_TXEMPTY = 2;
  localparam int B_ALLOC   = 3;
  localparam int B_OVRN    = 4;
  localparam int B_EXC     = 5;
  localparam int B_ERX     = 6;
  localparam int B_RSVD    = 7;
  // sticky, write-one-to-clear positions
  localparam logic [SW-1:0] ACKABLE    = 8'b0101_0110;
  localparam logic [SW-1:0] STATUS_RST = 8'b0000_0100;
endpackage

// File: rtl/irqu_host_port.sv
module irqu_host_port
  import irqu_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int BASE_WORD = 6
) (
  input  logic              hp_req,
  input  logic              hp_we,
  input  logic [ADDR_W-1:0] hp_addr,
  input  logic [1:0]        hp_be,
  input  logic [15:0]       hp_wdata,
  input  logic [SW-1:0]     status,
  input  logic [SW-1:0]     mask,
  output logic [SW-1:0]     ack_vec,
  output logic              mask_we,
  output logic [SW-1:0]     mask_wdata,
  output logic [15:0]       hp_rdata
);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_WORD);

  logic hit;
  logic wr_hit;
  logic rd_hit;

  always_comb begin
    hit    = hp_req && (hp_addr == BASE);
    wr_hit = hit && hp_we;
    rd_hit = hit && !hp_we;
  end

  always_comb begin
    ack_vec    = (wr_hit && hp_be[0]) ? (hp_wdata[SW-1:0] & ACKABLE) : '0;
    mask_we    = wr_hit && hp_be[1];
    mask_wdata = hp_wdata[15:8];
    hp_rdata   = rd_hit ? {mask, status} : 16'h0000;
  end
endmodule

// File: rtl/irqu_early_rx.sv
module irqu_early_rx #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_start,
  input  logic             rx_active,
  input  logic             rx_byte_stb,
  input  logic [CNT_W-1:0] threshold,
  output logic             fire
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_q, count_d;
  logic             armed_q, armed_d;
  logic             en;

  always_comb begin
    fire = armed_q && rx_active && !rx_start && (count_q > threshold);
  end

  always_comb begin
    count_d = count_q;
    armed_d = armed_q;
    if (rx_start) begin
      count_d = rx_byte_stb ? CNT_W'(1) : '0;
      armed_d = 1'b1;
    end else begin
      if (rx_byte_stb && (count_q != CNT_MAX)) count_d = count_q + 1'b1;
      if (fire) armed_d = 1'b0;
    end
    en = rx_start | rx_byte_stb | fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (en) begin
      count_q <= count_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/irqu_status_core.sv
module irqu_status_core
  import irqu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic [SW-1:0] live_vec,
  input  logic [SW-1:0] ack_vec,
  output logic [SW-1:0] status
);
  for (genvar i = 0; i < SW; i++) begin : g_bit
    if (ACKABLE[i]) begin : g_sticky
      logic q, d, en;
      logic unused_live;
      always_comb begin
        unused_live = live_vec[i];
        en = set_vec[i] | ack_vec[i];
        d  = set_vec[i] ? 1'b1 : 1'b0;   // set wins over acknowledge
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= STATUS_RST[i];
        else if (en) q <= d;
      end
      assign status[i] = q;
    end else if (i == B_RSVD) begin : g_rsvd
      logic unused_rsvd;
      assign unused_rsvd = set_vec[i] | live_vec[i] | ack_vec[i];
      assign status[i] = 1'b0;
    end else begin : g_live
      logic unused_in;
      assign unused_in = set_vec[i] | ack_vec[i];
      assign status[i] = live_vec[i];
    end
  end
endmodule

// File: rtl/irqu_mask_gate.sv
module irqu_mask_gate
  import irqu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mask_we,
  input  logic [SW-1:0] mask_wdata,
  input  logic [SW-1:0] status,
  output logic [SW-1:0] mask_q,
  output logic          irq
);
  logic [SW-1:0] mask_d;

  always_comb begin
    mask_d = mask_we ? mask_wdata : mask_q;
    irq    = |(status & mask_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_reg_unit.sv
module irq_reg_unit
  import irqu_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int BASE_WORD = 6,
  parameter int CNT_W     = 12,
  parameter int NEXC      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hp_req,
  input  logic              hp_we,
  input  logic [ADDR_W-1:0] hp_addr,
  input  logic [1:0]        hp_be,
  input  logic [15:0]       hp_wdata,
  output logic [15:0]       hp_rdata,
  input  logic              ev_rx_pending,
  input  logic              ev_alloc_done,
  input  logic              ev_tx_done,
  input  logic              ev_tx_empty,
  input  logic              ev_rx_overrun,
  input  logic [NEXC-1:0]   exc_src,
  input  logic              rx_start,
  input  logic              rx_active,
  input  logic              rx_byte_stb,
  input  logic [CNT_W-1:0]  erx_threshold,
  output logic              irq
);
  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic [SW-1:0] status_w, mask_w, ack_w, set_w, live_w, mask_wdata_w;
  logic          mask_we_w;
  logic          erx_fire_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  always_comb begin
    set_w            = '0;
    set_w[B_TXDONE]  = ev_tx_done;
    set_w[B_TXEMPTY] = ev_tx_empty;
    set_w[B_OVRN]    = ev_rx_overrun;
    set_w[B_ERX]     = erx_fire_w;
    live_w           = '0;
    live_w[B_RX]     = ev_rx_pending;
    live_w[B_ALLOC]  = ev_alloc_done;
    live_w[B_EXC]    = |exc_src;
  end

  irqu_host_port #(.ADDR_W(ADDR_W), .BASE_WORD(BASE_WORD)) u_port (
    .hp_req(hp_req), .hp_we(hp_we), .hp_addr(hp_addr), .hp_be(hp_be),
    .hp_wdata(hp_wdata), .status(status_w), .mask(mask_w),
    .ack_vec(ack_w), .mask_we(mask_we_w), .mask_wdata(mask_wdata_w),
    .hp_rdata(hp_rdata)
  );

  irqu_early_rx #(.CNT_W(CNT_W)) u_erx (
    .clk(clk), .rst_n(rst_sync_n), .rx_start(rx_start), .rx_active(rx_active),
    .rx_byte_stb(rx_byte_stb), .threshold(erx_threshold), .fire(erx_fire_w)
  );

  irqu_status_core u_core (
    .clk(clk), .rst_n(rst_sync_n), .set_vec(set_w), .live_vec(live_w),
    .ack_vec(ack_w), .status(status_w)
  );

  irqu_mask_gate u_mask (
    .clk(clk), .rst_n(rst_sync_n), .mask_we(mask_we_w),
    .mask_wdata(mask_wdata_w), .status(status_w), .mask_q(mask_w), .irq(irq)
  );
endmodule

// File: rtl/irqu_chk.sv
module irqu_chk
  import irqu_pkg::*;
#(
  parameter int NEXC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [SW-1:0]   status,
  input logic [SW-1:0]   mask_q,
  input logic [SW-1:0]   ack_vec,
  input logic [SW-1:0]   set_vec,
  input logic [NEXC-1:0] exc_src,
  input logic            mask_we,
  input logic            fire,
  input logic            irq
);
  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & ~ack_vec & ACKABLE)) == $past(status & ~ack_vec & ACKABLE)));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(ack_vec & ~set_vec & ACKABLE)) == '0));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_vec & ACKABLE)) == $past(set_vec & ACKABLE)));

  assert_exc_not_ackable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_src) |-> status[B_EXC]);

  assert_mask_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_q));

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_erx_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

bind irq_reg_unit irqu_chk #(.NEXC(NEXC)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .status(status_w), .mask_q(mask_w),
  .ack_vec(ack_w), .set_vec(set_w), .exc_src(exc_src), .mask_we(mask_we_w),
  .fire(erx_fire_w), .irq(irq)
);

// File: tb/irq_reg_unit_bench.sv
module irq_reg_unit_bench;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 12;
  localparam int NEXC   = 4;
  localparam logic [ADDR_W-1:0] REG_A = 3'd6;

  logic clk, rst_n, hp_req, hp_we;
  logic [ADDR_W-1:0] hp_addr;
  logic [1:0] hp_be;
  logic [15:0] hp_wdata, hp_rdata;
  logic ev_rx_pending, ev_alloc_done, ev_tx_done, ev_tx_empty, ev_rx_overrun;
  logic [NEXC-1:0] exc_src;
  logic rx_start, rx_active, rx_byte_stb;
  logic [CNT_W-1:0] erx_threshold;
  logic irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  irq_reg_unit u_irq_reg_unit (
    .clk(clk), .rst_n(rst_n), .hp_req(hp_req), .hp_we(hp_we), .hp_addr(hp_addr),
    .hp_be(hp_be), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata),
    .ev_rx_pending(ev_rx_pending), .ev_alloc_done(ev_alloc_done),
    .ev_tx_done(ev_tx_done), .ev_tx_empty(ev_tx_empty), .ev_rx_overrun(ev_rx_overrun),
    .exc_src(exc_src), .rx_start(rx_start), .rx_active(rx_active),
    .rx_byte_stb(rx_byte_stb), .erx_threshold(erx_threshold), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [15:0] v);
    @(negedge clk);
    hp_req = 1; hp_we = 0; hp_addr = a; hp_be = 2'b11;
    #1 v = hp_rdata;
    hp_req = 0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    hp_req = 1; hp_we = 1; hp_addr = a; hp_be = be; hp_wdata = d;
    @(negedge clk);
    hp_req = 0; hp_we = 0;
  endtask

  task automatic pulse_sticky(input bit td, input bit te, input bit ov);
    @(negedge clk);
    ev_tx_done = td; ev_tx_empty = te; ev_rx_overrun = ov;
    @(negedge clk);
    ev_tx_done = 0; ev_tx_empty = 0; ev_rx_overrun = 0;
  endtask

  task automatic strobe();
    @(negedge clk); rx_byte_stb = 1;
    @(negedge clk); rx_byte_stb = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, v2;
    rst_n = 0; hp_req = 0; hp_we = 0; hp_addr = '0; hp_be = 0; hp_wdata = 0;
    ev_rx_pending = 0; ev_alloc_done = 0; ev_tx_done = 0; ev_tx_empty = 0;
    ev_rx_overrun = 0; exc_src = 0; rx_start = 0; rx_active = 0; rx_byte_stb = 0;
    erx_threshold = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(REG_A, v);
    check("R1 reset word", v, 16'h0004);
    check("R1 reset irq", {15'd0, irq}, 16'h0000);

    // clear transmit-empty to start from zero
    wr(REG_A, 2'b01, 16'h0004);
    rd(REG_A, v);
    check("R3 ack tx_empty", v, 16'h0000);

    // R2 live bits sweep
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ev_rx_pending = k[0]; ev_alloc_done = k[1];
      rd(REG_A, v);
      check("R2 live bits", v, 16'(k[0]) | (16'(k[1]) << 3));
    end
    ev_rx_pending = 0; ev_alloc_done = 0;

    // R5 exception OR sweep, acknowledge immune
    for (int s = 0; s < 16; s++) begin
      @(negedge clk); exc_src = 4'(s);
      rd(REG_A, v);
      check("R5 exc or", v, (s != 0) ? 16'h0020 : 16'h0000);
    end
    exc_src = 4'b0100;
    wr(REG_A, 2'b01, 16'h00FF);
    rd(REG_A, v);
    check("R5 exc survives ack", v, 16'h0020);
    @(negedge clk); exc_src = 0;
    rd(REG_A, v);
    check("R5 exc clears with sources", v, 16'h0000);

    // R3 each sticky bit: set, hold, clear; R11 reads have no effect
    for (int b = 0; b < 3; b++) begin
      logic [15:0] bitv;
      bitv = (b == 0) ? 16'h0002 : (b == 1) ? 16'h0004 : 16'h0010;
      pulse_sticky(b == 0, b == 1, b == 2);
      repeat (3) @(negedge clk);
      rd(REG_A, v);
      rd(REG_A, v2);
      check("R3 sticky holds", v, bitv);
      check("R11 read no side effect", v2, bitv);
      wr(REG_A, 2'b01, bitv);
      rd(REG_A, v);
      check("R3 ack clears", v, 16'h0000);
    end

    // R4 acknowledge sweep over all byte values
    ev_rx_pending = 1; ev_alloc_done = 1;
    for (int a = 0; a < 256; a++) begin
      pulse_sticky(1, 1, 1);
      wr(REG_A, 2'b01, 16'(a));
      rd(REG_A, v);
      check("R4 ack sweep", v, 16'h0009 | (16'h0016 & ~16'(a)));
    end
    ev_rx_pending = 0; ev_alloc_done = 0;
    wr(REG_A, 2'b01, 16'h00FF);

    // R6 set and acknowledge in the same cycle
    @(negedge clk);
    ev_tx_done = 1; hp_req = 1; hp_we = 1; hp_addr = REG_A; hp_be = 2'b01; hp_wdata = 16'h0002;
    @(negedge clk);
    ev_tx_done = 0; hp_req = 0; hp_we = 0;
    rd(REG_A, v);
    check("R6 set wins", v, 16'h0002);

    // R7/R8 mask access and byte enables
    wr(REG_A, 2'b10, 16'hA5FF);
    rd(REG_A, v);
    check("R8 high-byte write keeps status", v, 16'hA502);
    wr(REG_A, 2'b01, 16'h3C00);
    rd(REG_A, v);
    check("R8 low-byte write keeps mask", v, 16'hA502);
    wr(3'd2, 2'b11, 16'h00FF);
    rd(REG_A, v);
    check("R8 other address ignored", v, 16'hA502);
    rd(3'd2, v);
    check("R8 other address reads 0", v, 16'h0000);
    wr(REG_A, 2'b11, 16'h5A02);
    rd(REG_A, v);
    check("R7 word write mask and ack", v, 16'h5A00);

    // R9 irq sweep over every mask for two status patterns
    for (int p = 0; p < 2; p++) begin
      logic [7:0] pat;
      @(negedge clk);
      if (p == 0) begin exc_src = 4'b0001; pat = 8'h20; end
      else begin exc_src = 0; ev_rx_pending = 1; ev_alloc_done = 1; pat = 8'h09; end
      for (int m = 0; m < 256; m++) begin
        wr(REG_A, 2'b10, 16'(m) << 8);
        #1;
        check("R9 irq vs mask", {15'd0, irq}, {15'd0, |(pat & 8'(m))});
      end
    end
    exc_src = 0; ev_rx_pending = 0; ev_alloc_done = 0;
    wr(REG_A, 2'b10, 16'h0000);

    // R10 early receive thresholds
    for (int t = 0; t < 4; t++) begin
      int thr;
      thr = (t == 3) ? 7 : t;
      @(negedge clk);
      erx_threshold = CNT_W'(thr); rx_active = 1; rx_start = 1;
      @(negedge clk); rx_start = 0;
      @(negedge clk);
      rd(REG_A, v);
      check("R10 cleared at start", v & 16'h0040, 16'h0000);
      for (int k = 1; k <= thr + 2; k++) begin
        strobe();
        rd(REG_A, v);
        check("R10 erx vs count", v & 16'h0040, (k > thr) ? 16'h0040 : 16'h0000);
      end
      wr(REG_A, 2'b01, 16'h0040);
      strobe(); strobe();
      rd(REG_A, v);
      check("R10 once per packet", v & 16'h0040, 16'h0000);
    end
    rx_active = 0;

    finish_run();
  end
endmodule